// File: doc/BRIEF.md
# Mixed-Mode Interrupt Status Unit

This block gathers five interrupt sources from a converter peripheral and presents them on a simple 32-bit register bus. Software sees three views of the sources: a raw view before masking, an enable mask, and a masked view. The block also drives one combined interrupt line.

Three sources are event-type: brownout, pen touch and end of a conversion sequence. Each arrives as a single-cycle pulse on the bus clock. The pulse sets a sticky bit, and that bit stays set until software writes a one to the matching bit of the clear register. The other two sources are level-type: FIFO-above-watermark and FIFO overrun. They mirror threshold comparisons made outside the block and drop by themselves once the condition ends.

Register map (word offsets, byte addressed): 0x0 raw status (read-only), 0x4 enable (read/write), 0x8 masked status (read-only), 0xC clear (write-only, reads zero). An address that matches none of these reads zero and ignores writes. Reads are combinational from `busAddr`. A write takes effect on the clock edge where `busSel` and `busWrite` are both high.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, the raw, enable and masked registers read 0 and `irqOut` is 0.
- R2: Bits 31 down to 5 of every register read as 0. Writes to the raw and masked offsets change nothing, and the clear offset reads 0.
- R3: The five-bit field places brownout at bit 4, pen at bit 3, sequence end at bit 2, FIFO watermark at bit 1 and FIFO overrun at bit 0, in both the raw and the masked register.
- R4: An event pulse sets its raw bit at the clock edge where the pulse is sampled. The bit then stays 1 through later cycles until it is cleared.
- R5: Writing 1 to clear-register bit 4, 3 or 2 clears that latched bit. Writing 1 to clear bits 1 or 0, or to bits 31 to 5, has no effect.
- R6: An event pulse and a clear of the same bit in the same cycle leave the bit set.
- R7: Raw bits 1 and 0 follow `fifoWaterHigh` and `fifoOverrun` in the same cycle and are never latched.
- R8: Each masked bit reads 1 exactly when its raw bit and its enable bit are both 1.
- R9: Latched bits set and hold in the raw register even while their enable bit is 0.
- R10: `irqOut` equals the OR of the masked bits as they stood one clock earlier.
- R11: The enable register stores bits 4 to 0 of a write to offset 0x4 and reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Byte address within the block |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| evtBrownout | input | 1 | Brownout event pulse |
| evtPen | input | 1 | Pen-touch event pulse |
| evtSeqEnd | input | 1 | Conversion-sequence-end pulse |
| fifoWaterHigh | input | 1 | FIFO above watermark level |
| fifoOverrun | input | 1 | FIFO overrun level |
| irqOut | output | 1 | Registered combined interrupt |

## Verification
The hardest situation to reach from the ports is an event pulse landing in the same clock cycle as a software clear of the same bit. The stimulus drives the event input and the clear write on the same falling edge, so both are sampled by one rising edge, and then reads the raw register to confirm the bit survived. A sweep over all 32 enable masks against all 32 source patterns builds each pattern from fresh pulses and levels. This sweep covers bit placement, masking and the one-cycle lag of the interrupt line.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int NUM_EVT = 3;
  localparam int NUM_LVL = 2;
  localparam int NUM_SRC = NUM_EVT + NUM_LVL;

  typedef enum logic [2:0] {
    SEL_RAW,
    SEL_ENABLE,
    SEL_MASKED,
    SEL_CLEAR,
    SEL_NONE
  } regSel_e;

  typedef struct packed {
    logic                wrEnable;
    logic                wrClear;
    logic [NUM_SRC-1:0]  wrBits;
    regSel_e             rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output ctrlStrobes_t      strobes
);
  localparam logic [ADDR_W-1:0] OFF_RAW    = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFF_ENABLE = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFF_MASKED = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] OFF_CLEAR  = ADDR_W'(4'hC);

  regSel_e sel;
  logic    wrAccess;
  logic    unusedWdata;

  assign unusedWdata = ^busWdata[DATA_W-1:NUM_SRC];
  assign wrAccess    = busSel && busWrite;

  always_comb begin
    case (busAddr)
      OFF_RAW:    sel = SEL_RAW;
      OFF_ENABLE: sel = SEL_ENABLE;
      OFF_MASKED: sel = SEL_MASKED;
      OFF_CLEAR:  sel = SEL_CLEAR;
      default:    sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobes.rdSel    = sel;
    strobes.wrEnable = wrAccess && (sel == SEL_ENABLE);
    strobes.wrClear  = wrAccess && (sel == SEL_CLEAR);
    strobes.wrBits   = busWdata[NUM_SRC-1:0];
  end
endmodule

// File: rtl/irq_status_datapath.sv
module irq_status_datapath
  import irq_status_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic [NUM_LVL-1:0] lvlIn,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  logic [NUM_EVT-1:0] latched;
  logic [NUM_SRC-1:0] rawBits;
  logic [NUM_SRC-1:0] enReg;
  logic [NUM_SRC-1:0] maskedBits;
  logic               irqReg;

  // Sticky event bits: a pulse outranks a clear in the same cycle.
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_latch
    always_ff @(posedge clk) begin
      if (!rstN)
        latched[g] <= 1'b0;
      else if (evtIn[g])
        latched[g] <= 1'b1;
      else if (strobes.wrClear && strobes.wrBits[NUM_LVL+g])
        latched[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      enReg <= '0;
    else if (strobes.wrEnable)
      enReg <= strobes.wrBits;
  end

  assign rawBits    = {latched, lvlIn};
  assign maskedBits = rawBits & enReg;

  always_ff @(posedge clk) begin
    if (!rstN)
      irqReg <= 1'b0;
    else
      irqReg <= |maskedBits;
  end
  assign irqOut = irqReg;

  always_comb begin
    rdData = '0;
    case (strobes.rdSel)
      SEL_RAW:    rdData[NUM_SRC-1:0] = rawBits;
      SEL_ENABLE: rdData[NUM_SRC-1:0] = enReg;
      SEL_MASKED: rdData[NUM_SRC-1:0] = maskedBits;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              evtBrownout,
  input  logic              evtPen,
  input  logic              evtSeqEnd,
  input  logic              fifoWaterHigh,
  input  logic              fifoOverrun,
  output logic              irqOut
);
  ctrlStrobes_t strobes;

  irq_status_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strobes  (strobes)
  );

  irq_status_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .evtIn   ({evtBrownout, evtPen, evtSeqEnd}),
    .lvlIn   ({fifoWaterHigh, fifoOverrun}),
    .rdData  (busRdata),
    .irqOut  (irqOut)
  );
endmodule

// File: rtl/irq_status_checker.sv
module irq_status_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [4:0]        clrBits,
  input logic [DATA_W-1:5] rdUpper,
  input logic              evtBrownout,
  input logic              evtPen,
  input logic              evtSeqEnd,
  input logic              irqOut,
  input logic [4:0]        rawBits,
  input logic [4:0]        enBits
);
  logic clrWr;
  assign clrWr = busSel && busWrite && (busAddr == ADDR_W'(4'hC));

  // R4 / R6: a brownout pulse always leaves the bit set on the next cycle
  a_r4_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    evtBrownout |=> rawBits[4]);

  // R6: pen pulse plus clear of bit 3 in the same cycle keeps the bit
  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (evtPen && clrWr && clrBits[3]) |=> rawBits[3]);

  // R4: without a clear, a latched sequence-end bit holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rawBits[2] && !(clrWr && clrBits[2])) |=> rawBits[2]);

  // R5: clear without a competing event drops the bit
  a_r5_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && clrBits[2] && !evtSeqEnd) |=> !rawBits[2]);

  // R10: interrupt line lags the masked OR by one cycle
  a_r10_irq_lag: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(rawBits & enBits))));

  // R2: upper read bits are always zero
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdUpper == '0);
endmodule

bind irq_status_unit irq_status_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busSel      (busSel),
  .busWrite    (busWrite),
  .busAddr     (busAddr),
  .clrBits     (busWdata[4:0]),
  .rdUpper     (busRdata[DATA_W-1:5]),
  .evtBrownout (evtBrownout),
  .evtPen      (evtPen),
  .evtSeqEnd   (evtSeqEnd),
  .irqOut      (irqOut),
  .rawBits     (u_dp.rawBits),
  .enBits      (u_dp.enReg)
);

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = 4'h0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        evtBrownout = 1'b0;
  logic        evtPen = 1'b0;
  logic        evtSeqEnd = 1'b0;
  logic        fifoWaterHigh = 1'b0;
  logic        fifoOverrun = 1'b0;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  localparam logic [3:0] A_RAW = 4'h0, A_EN = 4'h4, A_MSK = 4'h8, A_CLR = 4'hC;

  irq_status_unit uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .evtBrownout(evtBrownout), .evtPen(evtPen), .evtSeqEnd(evtSeqEnd),
    .fifoWaterHigh(fifoWaterHigh), .fifoOverrun(fifoOverrun), .irqOut(irqOut)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic busWr(input logic [3:0] a, input logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic busRd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRd(A_RAW, rd); check("R1 raw", rd, 32'h0);
    busRd(A_EN, rd);  check("R1 enable", rd, 32'h0);
    busRd(A_MSK, rd); check("R1 masked", rd, 32'h0);
    check("R1 irqOut", {31'b0, irqOut}, 32'h0);

    // R11 / R2 enable write and upper bits
    busWr(A_EN, 32'hFFFF_FFFF);
    busRd(A_EN, rd); check("R11 R2 enable readback", rd, 32'h1F);
    busWr(A_EN, 32'h0000_000A);
    busRd(A_EN, rd); check("R11 enable readback", rd, 32'h0A);
    busWr(A_EN, 32'h0);
    busWr(A_RAW, 32'hFFFF_FFFF);
    busRd(A_RAW, rd); check("R2 raw write ignored", rd, 32'h0);
    busWr(A_MSK, 32'hFFFF_FFFF);
    busRd(A_MSK, rd); check("R2 masked write ignored", rd, 32'h0);
    busRd(A_CLR, rd); check("R2 clear reads zero", rd, 32'h0);

    // R4 / R9 latching while disabled
    evtBrownout = 1'b1; @(negedge clk); evtBrownout = 1'b0;
    busRd(A_RAW, rd); check("R4 R9 brownout latched", rd, 32'h10);
    repeat (4) @(negedge clk);
    busRd(A_RAW, rd); check("R4 brownout holds", rd, 32'h10);
    busRd(A_MSK, rd); check("R9 masked stays low", rd, 32'h0);
    evtPen = 1'b1; @(negedge clk); evtPen = 1'b0;
    busRd(A_RAW, rd); check("R4 pen latched", rd, 32'h18);

    // R7 level sources
    fifoWaterHigh = 1'b1; fifoOverrun = 1'b1;
    busRd(A_RAW, rd); check("R7 levels high", rd, 32'h1B);

    // R5 clear bits 1,0 and reserved: no effect
    busWr(A_CLR, 32'hFFFF_FFE3);
    busRd(A_RAW, rd); check("R5 level and reserved clear ignored", rd, 32'h1B);
    busWr(A_CLR, 32'h0000_0008);
    busRd(A_RAW, rd); check("R5 pen cleared", rd, 32'h13);
    fifoOverrun = 1'b0;
    busRd(A_RAW, rd); check("R7 overrun drops", rd, 32'h12);
    fifoWaterHigh = 1'b0;
    busRd(A_RAW, rd); check("R7 water drops", rd, 32'h10);
    busWr(A_CLR, 32'h0000_0010);
    busRd(A_RAW, rd); check("R5 brownout cleared", rd, 32'h0);

    // R6 event beats clear in the same cycle
    evtSeqEnd = 1'b1;
    busWr(A_CLR, 32'h0000_0004);
    evtSeqEnd = 1'b0;
    busRd(A_RAW, rd); check("R6 event wins", rd, 32'h04);
    busWr(A_CLR, 32'h0000_0004);
    busRd(A_RAW, rd); check("R5 seq end cleared", rd, 32'h0);

    // R10 one-cycle lag
    evtSeqEnd = 1'b1; @(negedge clk); evtSeqEnd = 1'b0;
    busWr(A_EN, 32'h04);
    check("R10 irq not yet", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    check("R10 irq asserted", {31'b0, irqOut}, 32'h1);
    busWr(A_CLR, 32'h04);
    check("R10 irq still high", {31'b0, irqOut}, 32'h1);
    @(negedge clk);
    check("R10 irq dropped", {31'b0, irqOut}, 32'h0);

    // R3 / R8 / R10 sweep: every enable mask against every source pattern
    for (int en = 0; en < 32; en++) begin
      for (int pat = 0; pat < 32; pat++) begin
        logic [4:0] p;
        logic [4:0] e;
        p = 5'(pat);
        e = 5'(en);
        busWr(A_CLR, 32'h1C);
        fifoWaterHigh = p[1]; fifoOverrun = p[0];
        evtBrownout = p[4]; evtPen = p[3]; evtSeqEnd = p[2];
        busWr(A_EN, {27'b0, e});
        evtBrownout = 1'b0; evtPen = 1'b0; evtSeqEnd = 1'b0;
        busRd(A_RAW, rd); check("R3 raw pattern", rd, {27'b0, p});
        busRd(A_MSK, rd); check("R8 R3 masked pattern", rd, {27'b0, p & e});
        @(negedge clk);
        check("R10 sweep irq", {31'b0, irqOut}, {31'b0, |(p & e)});
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule